// File: doc/BRIEF.md
# Floppy Controller Reset Manager

This block decides when the core of a floppy disk controller is held in reset. Three things can put it there. The first is a global pin reset, which covers power-on. The second is a reset bit in the output control register. It is sticky: it stays set until the host clears it. The third is a reset bit in the rate select register, which clears itself after a fixed count of cycles. The block merges these sources into one core reset. It also decides which stored settings survive each kind of reset.

The host writes four registers through one write port: output control, rate select, timing parameters (the Specify settings) and Configure settings. A mode input selects the AT register behaviour. That mode changes the polarity of the terminal-count and density strobes and decides whether the DMA enable bit takes effect. A read-only status byte reflects the drive sense pins.

Top module: `fdc_rst_mgr`

## Requirements
- R1: While `por` or `hw_rst` is high, `core_rst` is high and `ctrl_q` bit 2 (the sticky reset bit, 0 = reset) is forced to 0. After the pin reset falls, `core_rst` stays high until the host writes the output control register with bit 2 set.
- R2: Writing the output control register (`wr_sel` = 00) with bit 2 clear raises `core_rst` from the next cycle. It stays high until a later write with bit 2 set, after which it falls on the next cycle.
- R3: Writing the rate select register (`wr_sel` = 01) with bit 7 set, while no reset is active, holds `core_rst` high for exactly 4 cycles, after which it falls by itself. A further request made while that count is running is ignored and does not lengthen it.
- R4: The sticky reset takes precedence. A rate-select reset request made while bit 2 of the output control register is clear is discarded, so setting bit 2 ends the reset on the next cycle. Clearing bit 2 during a running self-clearing count cancels that count.
- R5: A rate-select write with bit 6 set and bit 7 clear sets `pwr_down` from the next cycle. Any reset clears `pwr_down` one cycle after `core_rst` rises.
- R6: The timing parameter register (`wr_sel` = 10) keeps its value through `hw_rst` and through both software resets. Only `por` clears it to 0.
- R7: While `core_rst` is high, the Configure register (`wr_sel` = 11) reads 0, `poll_en` is 1 and writes to it are ignored. Outside reset, a write loads the register, and `poll_en` becomes the inverse of data bit 4.
- R8: `stat_q` is {0, write-protect pin, 1, track-0 pin, 1, head-select pin, drive-select pins[1:0]}, bit 7 first.
- R9: With `at_mode` = 1, `dma_gate` follows `ctrl_q` bit 3, and `tc_out` and `dens_out` equal `tc_in` and `dens_in`. With `at_mode` = 0, `dma_gate` is 1 and both strobes are inverted.
- R10: `ctrl_q` returns the last value written to the output control register and reads 0 after a pin reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| hw_rst | input | 1 | Global reset pin, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 00 output control, 01 rate select, 10 timing parameters, 11 Configure |
| wr_data | input | DATA_W | Write data |
| at_mode | input | 1 | 1 selects AT register behaviour |
| tc_in | input | 1 | Terminal count from the core, true high |
| dens_in | input | 1 | Density select from the core, true high |
| pin_wp | input | 1 | Write-protect sense |
| pin_trk0 | input | 1 | Track-0 sense |
| pin_hdsel | input | 1 | Head-select level |
| pin_ds | input | 2 | Drive-select levels |
| core_rst | output | 1 | Reset to the controller core |
| pwr_down | output | 1 | Power-down state |
| ctrl_q | output | DATA_W | Output control register readback |
| spec_q | output | DATA_W | Timing parameter register |
| cfg_q | output | DATA_W | Configure register |
| poll_en | output | 1 | Drive polling enabled |
| stat_q | output | 8 | Drive status byte |
| dma_gate | output | 1 | DMA request and interrupt outputs enabled |
| tc_out | output | 1 | Terminal count at pin polarity |
| dens_out | output | 1 | Density select at pin polarity |

## Verification
A wrong reset count shows up on `core_rst` within five cycles of a rate-select write. It appears as a pulse that is too short or too long, or as a reset that never ends after the sticky bit is released. A wrong choice of preserved state only becomes visible after a reset falls. There the timing parameter byte or the Configure byte reads back wrong, or `poll_en` disagrees, on the first cycle after release. A precedence error is caught by releasing the sticky bit and checking that `core_rst` falls on the very next cycle.

// File: rtl/fdc_rst_pkg.sv
package fdc_rst_pkg;
   typedef enum logic [1:0] {
      WSEL_CTRL = 2'd0,
      WSEL_RATE = 2'd1,
      WSEL_SPEC = 2'd2,
      WSEL_CFG  = 2'd3
   } wsel_e;

   localparam int CTRL_RST_BIT     = 2;   // 0 holds the core in reset
   localparam int CTRL_DMA_BIT     = 3;
   localparam int RATE_SRST_BIT    = 7;   // self-clearing reset request
   localparam int RATE_PD_BIT      = 6;   // power-down request
   localparam int CFG_POLL_OFF_BIT = 4;   // 1 disables drive polling
endpackage

// File: rtl/fdc_rst_arb.sv
module fdc_rst_arb
   import fdc_rst_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SELF_RST_CYC = 4
) (
   input  logic              clk,
   input  logic              por,
   input  logic              hw_rst,
   input  logic              ctrl_we,
   input  logic              rate_we,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              core_rst,
   output logic              pwr_down
);
   localparam int CNT_W = $clog2(SELF_RST_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SELF_RST_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             pin_rst, sticky_rst, self_rst;

   assign pin_rst    = por | hw_rst;
   assign sticky_rst = ~ctrl_q[CTRL_RST_BIT];
   assign self_rst   = (cnt_q != '0);
   assign core_rst   = pin_rst | sticky_rst | self_rst;

   always_ff @(posedge clk) begin
      if (pin_rst) begin
         ctrl_q   <= '0;
         cnt_q    <= '0;
         pwr_down <= 1'b0;
      end else begin
         if (ctrl_we)
            ctrl_q <= wr_data;

         // sticky reset wins: clearing it cancels a running count,
         // and a self-clearing request made under it is dropped
         if (ctrl_we && !wr_data[CTRL_RST_BIT])
            cnt_q <= '0;
         else if (rate_we && wr_data[RATE_SRST_BIT] && !sticky_rst && !self_rst)
            cnt_q <= CNT_LOAD;
         else if (self_rst)
            cnt_q <= cnt_q - 1'b1;

         if (core_rst)
            pwr_down <= 1'b0;
         else if (rate_we && wr_data[RATE_PD_BIT] && !wr_data[RATE_SRST_BIT])
            pwr_down <= 1'b1;
      end
   end
endmodule

// File: rtl/fdc_rst_cfg.sv
module fdc_rst_cfg
   import fdc_rst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              por,
   input  logic              core_rst,
   input  logic              spec_we,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] spec_q,
   output logic [DATA_W-1:0] cfg_q,
   output logic              poll_en
);
   // timing parameters: only power-on clears them
   always_ff @(posedge clk) begin
      if (por)
         spec_q <= '0;
      else if (spec_we)
         spec_q <= wr_data;
   end

   // Configure settings: wiped by any reset, polling back on
   always_ff @(posedge clk) begin
      if (core_rst) begin
         cfg_q   <= '0;
         poll_en <= 1'b1;
      end else if (cfg_we) begin
         cfg_q   <= wr_data;
         poll_en <= ~wr_data[CFG_POLL_OFF_BIT];
      end
   end
endmodule

// File: rtl/fdc_rst_pins.sv
module fdc_rst_pins #(
   parameter int N_STB = 2
) (
   input  logic             at_mode,
   input  logic [N_STB-1:0] stb_in,
   input  logic             dma_bit,
   input  logic             pin_wp,
   input  logic             pin_trk0,
   input  logic             pin_hdsel,
   input  logic [1:0]       pin_ds,
   output logic [N_STB-1:0] stb_out,
   output logic             dma_gate,
   output logic [7:0]       stat_q
);
   for (genvar i = 0; i < N_STB; i++) begin : g_stb
      assign stb_out[i] = at_mode ? stb_in[i] : ~stb_in[i];
   end

   assign dma_gate = at_mode ? dma_bit : 1'b1;
   assign stat_q   = {1'b0, pin_wp, 1'b1, pin_trk0, 1'b1, pin_hdsel, pin_ds};
endmodule

// File: rtl/fdc_rst_mgr.sv
module fdc_rst_mgr
   import fdc_rst_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SELF_RST_CYC = 4
) (
   input  logic              clk,
   input  logic              por,
   input  logic              hw_rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              at_mode,
   input  logic              tc_in,
   input  logic              dens_in,
   input  logic              pin_wp,
   input  logic              pin_trk0,
   input  logic              pin_hdsel,
   input  logic [1:0]        pin_ds,
   output logic              core_rst,
   output logic              pwr_down,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] spec_q,
   output logic [DATA_W-1:0] cfg_q,
   output logic              poll_en,
   output logic [7:0]        stat_q,
   output logic              dma_gate,
   output logic              tc_out,
   output logic              dens_out
);
   if (DATA_W < 8) begin : g_bad_width
      $error("fdc_rst_mgr: DATA_W must be at least 8");
   end
   if (SELF_RST_CYC < 1) begin : g_bad_cyc
      $error("fdc_rst_mgr: SELF_RST_CYC must be at least 1");
   end

   wsel_e      sel;
   logic       ctrl_we, rate_we, spec_we, cfg_we;
   logic [1:0] stb_in, stb_out;

   assign sel     = wsel_e'(wr_sel);
   assign ctrl_we = wr_en && (sel == WSEL_CTRL);
   assign rate_we = wr_en && (sel == WSEL_RATE);
   assign spec_we = wr_en && (sel == WSEL_SPEC);
   assign cfg_we  = wr_en && (sel == WSEL_CFG);

   fdc_rst_arb #(.DATA_W(DATA_W), .SELF_RST_CYC(SELF_RST_CYC)) u_arb (
      .clk      (clk),
      .por      (por),
      .hw_rst   (hw_rst),
      .ctrl_we  (ctrl_we),
      .rate_we  (rate_we),
      .wr_data  (wr_data),
      .ctrl_q   (ctrl_q),
      .core_rst (core_rst),
      .pwr_down (pwr_down)
   );

   fdc_rst_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk      (clk),
      .por      (por),
      .core_rst (core_rst),
      .spec_we  (spec_we),
      .cfg_we   (cfg_we),
      .wr_data  (wr_data),
      .spec_q   (spec_q),
      .cfg_q    (cfg_q),
      .poll_en  (poll_en)
   );

   assign stb_in = {dens_in, tc_in};

   fdc_rst_pins #(.N_STB(2)) u_pins (
      .at_mode   (at_mode),
      .stb_in    (stb_in),
      .dma_bit   (ctrl_q[CTRL_DMA_BIT]),
      .pin_wp    (pin_wp),
      .pin_trk0  (pin_trk0),
      .pin_hdsel (pin_hdsel),
      .pin_ds    (pin_ds),
      .stb_out   (stb_out),
      .dma_gate  (dma_gate),
      .stat_q    (stat_q)
   );

   assign tc_out   = stb_out[0];
   assign dens_out = stb_out[1];
endmodule

// File: rtl/fdc_rst_mgr_chk.sv
module fdc_rst_mgr_chk
   import fdc_rst_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SELF_RST_CYC = 4
) (
   input logic              clk,
   input logic              por,
   input logic              hw_rst,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              core_rst,
   input logic              pwr_down,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] spec_q,
   input logic [DATA_W-1:0] cfg_q,
   input logic              poll_en
);
   localparam int RUN_W = $clog2(SELF_RST_CYC + 2) + 1;

   logic [RUN_W-1:0] run_q;
   logic             self_window;

   // reset cycles seen while neither pin nor sticky reset is active
   assign self_window = core_rst && ctrl_q[CTRL_RST_BIT] && !hw_rst && !por;

   always_ff @(posedge clk) begin
      if (por)
         run_q <= '0;
      else if (self_window)
         run_q <= run_q + 1'b1;
      else
         run_q <= '0;
   end

   AST_PIN_STICKY: assert property (@(posedge clk) disable iff (por)
      hw_rst |=> (!ctrl_q[CTRL_RST_BIT] && core_rst)); // R1

   AST_STICKY_SET: assert property (@(posedge clk) disable iff (por)
      (wr_en && wr_sel == WSEL_CTRL && !wr_data[CTRL_RST_BIT]) |=> core_rst); // R2

   AST_SELF_LEN: assert property (@(posedge clk) disable iff (por)
      run_q <= RUN_W'(SELF_RST_CYC)); // R3

   AST_PD_EXIT: assert property (@(posedge clk) disable iff (por)
      core_rst |=> !pwr_down); // R5

   AST_SPEC_KEPT: assert property (@(posedge clk) disable iff (por)
      !(wr_en && wr_sel == WSEL_SPEC) |=> $stable(spec_q)); // R6

   AST_CFG_CLR: assert property (@(posedge clk) disable iff (por)
      core_rst |=> (cfg_q == '0 && poll_en)); // R7
endmodule

bind fdc_rst_mgr fdc_rst_mgr_chk #(.DATA_W(DATA_W), .SELF_RST_CYC(SELF_RST_CYC)) u_chk (
   .clk      (clk),
   .por      (por),
   .hw_rst   (hw_rst),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .core_rst (core_rst),
   .pwr_down (pwr_down),
   .ctrl_q   (ctrl_q),
   .spec_q   (spec_q),
   .cfg_q    (cfg_q),
   .poll_en  (poll_en)
);

// File: tb/tb_fdc_rst_mgr.sv
module tb_fdc_rst_mgr;
   logic       clk = 1'b0;
   logic       por = 1'b1, hw_rst = 1'b0, wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic       at_mode = 1'b1, tc_in = 1'b0, dens_in = 1'b0;
   logic       pin_wp = 1'b0, pin_trk0 = 1'b0, pin_hdsel = 1'b0;
   logic [1:0] pin_ds = 2'd0;
   logic       core_rst, pwr_down, poll_en, dma_gate, tc_out, dens_out;
   logic [7:0] ctrl_q, spec_q, cfg_q, stat_q;

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   fdc_rst_mgr dut (
      .clk(clk), .por(por), .hw_rst(hw_rst), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .at_mode(at_mode), .tc_in(tc_in), .dens_in(dens_in),
      .pin_wp(pin_wp), .pin_trk0(pin_trk0), .pin_hdsel(pin_hdsel), .pin_ds(pin_ds),
      .core_rst(core_rst), .pwr_down(pwr_down), .ctrl_q(ctrl_q), .spec_q(spec_q),
      .cfg_q(cfg_q), .poll_en(poll_en), .stat_q(stat_q), .dma_gate(dma_gate),
      .tc_out(tc_out), .dens_out(dens_out)
   );

   // packing: [7]=at_mode [6]=tc [5]=dens [4]=wp [3]=trk0 [2]=hdsel [1:0]=ds
   localparam logic [7:0] VEC [8] = '{
      8'h80, 8'hC5, 8'hA6, 8'h93, 8'h08, 8'h4C, 8'h31, 8'hFF
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog expired, run did not complete");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk("R1 core_rst under por", {31'd0, core_rst}, 1);
      chk("R10 ctrl_q after por", {24'd0, ctrl_q}, 0);
      chk("R6 spec_q after por", {24'd0, spec_q}, 0);
      chk("R7 cfg_q/poll_en under reset", {23'd0, cfg_q, poll_en}, {23'd0, 8'h00, 1'b1});
      chk("R5 pwr_down after por", {31'd0, pwr_down}, 0);
      por = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 core_rst held after pin release", {31'd0, core_rst}, 1);

      wr(2'd2, 8'hA5);
      chk("R6 spec write", {24'd0, spec_q}, 32'hA5);
      wr(2'd0, 8'h0C);
      chk("R2 release by bit2", {31'd0, core_rst}, 0);
      chk("R10 ctrl_q readback", {24'd0, ctrl_q}, 32'h0C);

      // table walk: status layout and strobe polarity
      foreach (VEC[i]) begin
         logic [7:0] v;
         v = VEC[i];
         @(negedge clk);
         at_mode = v[7]; tc_in = v[6]; dens_in = v[5];
         pin_wp = v[4]; pin_trk0 = v[3]; pin_hdsel = v[2]; pin_ds = v[1:0];
         #2;
         chk("R8 status byte", {24'd0, stat_q}, {24'd0, 1'b0, v[4], 1'b1, v[3], 1'b1, v[2], v[1:0]});
         chk("R9 strobes/dma", {29'd0, tc_out, dens_out, dma_gate},
             {29'd0, v[7] ? v[6] : ~v[6], v[7] ? v[5] : ~v[5], 1'b1});
      end

      @(negedge clk); at_mode = 1'b1;
      wr(2'd0, 8'h04);
      chk("R9 dma_gate follows bit3 in AT mode", {31'd0, dma_gate}, 0);
      at_mode = 1'b0; #2;
      chk("R9 dma_gate forced in other mode", {31'd0, dma_gate}, 1);
      at_mode = 1'b1;

      wr(2'd3, 8'h10);
      chk("R7 cfg write", {23'd0, cfg_q, poll_en}, {23'd0, 8'h10, 1'b0});

      // self-clearing reset length
      wr(2'd1, 8'h80);
      n = 0;
      for (int i = 0; i < 12; i++) begin
         if (!core_rst) break;
         n++;
         @(negedge clk);
      end
      chk("R3 self reset length", n, 4);
      chk("R7 cfg cleared by reset", {23'd0, cfg_q, poll_en}, {23'd0, 8'h00, 1'b1});
      chk("R6 spec kept over soft reset", {24'd0, spec_q}, 32'hA5);

      // second request during count is ignored
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h80;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      n = 1;
      for (int i = 0; i < 12; i++) begin
         if (!core_rst) break;
         n++;
         @(negedge clk);
      end
      chk("R3 repeated request ignored", n, 4);

      // power-down
      wr(2'd1, 8'h40);
      chk("R5 power-down entered", {31'd0, pwr_down}, 1);
      wr(2'd1, 8'h80);
      @(negedge clk);
      chk("R5 reset exits power-down", {31'd0, pwr_down}, 0);
      repeat (5) @(negedge clk);

      // precedence
      wr(2'd0, 8'h08);
      chk("R2 sticky reset asserted", {31'd0, core_rst}, 1);
      wr(2'd1, 8'h80);
      wr(2'd0, 8'h0C);
      chk("R4 request under sticky discarded", {31'd0, core_rst}, 0);
      wr(2'd1, 8'h80);
      wr(2'd0, 8'h08);
      wr(2'd0, 8'h0C);
      chk("R4 sticky cancels count", {31'd0, core_rst}, 0);

      // pin reset keeps spec, clears ctrl, wipes power-down
      wr(2'd1, 8'h40);
      @(negedge clk); hw_rst = 1'b1;
      @(negedge clk); hw_rst = 1'b0;
      chk("R1 sticky bit forced", {24'd0, ctrl_q}, 0);
      chk("R5 pin reset clears pwr_down", {31'd0, pwr_down}, 0);
      @(negedge clk);
      chk("R1 core_rst after hw_rst", {31'd0, core_rst}, 1);
      chk("R6 spec kept over hw_rst", {24'd0, spec_q}, 32'hA5);
      wr(2'd3, 8'h10);
      chk("R7 cfg write in reset ignored", {23'd0, cfg_q, poll_en}, {23'd0, 8'h00, 1'b1});
      wr(2'd0, 8'h04);
      chk("R1 exit after host sets bit2", {31'd0, core_rst}, 0);

      @(negedge clk); por = 1'b1;
      @(negedge clk); por = 1'b0;
      chk("R6 por clears spec", {24'd0, spec_q}, 0);

      finish_run();
   end
endmodule